// File: doc/BRIEF.md
# TMDS Clock Rate PLL Mode Selector

This block watches an incoming TMDS clock and works out how a serial transceiver quad should set up its two shared PLLs to receive it. It counts TMDS clock edges over a fixed window of reference-clock cycles and sorts the count into one of three operating modes. Below 80 MHz the receiver has to oversample through a separate data-recovery unit on a fixed 2.5 GHz VCO. From 80 MHz up to 165 MHz the native CDR runs with a ×20 feedback multiplier. Above 165 MHz and below 330 MHz the native CDR runs with ×10. Anything at or above 330 MHz, or a setting whose VCO would leave the 1.6 to 3.3 GHz window, is reported as unsupported. A stopped clock is reported as its own status.

The quad has no PLL per channel. There are two identical shared PLLs, and a configuration input picks the one that transmit uses. Receive always gets the other one. A new PLL setting is only declared valid once two windows in a row land in the same mode, so a clock that sits close to a threshold does not make the setting flip back and forth. All outputs are registered. Status and settings change only in the second cycle after a window closes.

Top module: `tmds_pll_mode_sel`

## Requirements
- R1: While reset is asserted, cfgValid, noClock, unsupported, useDru, refDiv, fbMult and txPll are 0 and rxPll is 1.
- R2: A window lasts WIN_CYCLES reference cycles. cfgValid, refDiv, fbMult, useDru, noClock and unsupported change only on the edge two cycles after a window closes. At all other times they hold their values.
- R3: A count above zero and below the 80 MHz count selects the oversampling mode: useDru=1, refDiv=2 (binary 10), fbMult=25.
- R4: A count from the 80 MHz count up to and including the 165 MHz count selects the ×20 CDR mode: useDru=0, refDiv=1, fbMult=20. A count of exactly 165 MHz belongs to this mode.
- R5: A count above the 165 MHz count and below the 330 MHz count selects the ×10 CDR mode: useDru=0, refDiv=1, fbMult=10.
- R6: A count at or above the 330 MHz count sets unsupported=1 and cfgValid=0 at that window's decision.
- R7: A zero count sets noClock=1 and cfgValid=0 at that window's decision. noClock and unsupported are both 0 whenever cfgValid is 1.
- R8: cfgValid becomes 1 only when the current window and the one before it fall in the same supported mode. The first decision after reset never raises it.
- R9: txPll follows txPllSel one cycle later (0 names the first PLL, 1 the second). rxPll is always the complement of txPll.
- R10: In the CDR modes the count times fbMult must lie between the 1.6 GHz and 3.3 GHz equivalents, inclusive, for a setting to become valid. Otherwise unsupported is raised.
- R11: refDiv, fbMult and useDru keep the last confirmed setting across decisions that do not confirm a mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock of known frequency REF_KHZ |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| tmdsClk | input | 1 | TMDS clock to be measured |
| txPllSel | input | 1 | PLL given to transmit (0 first, 1 second) |
| cfgValid | output | 1 | Confirmed PLL setting present |
| refDiv | output | 2 | PLL reference divider |
| fbMult | output | 5 | PLL feedback multiplier |
| useDru | output | 1 | Oversampling data-recovery unit needed instead of CDR |
| noClock | output | 1 | Last window counted no TMDS edges |
| unsupported | output | 1 | Last window rate cannot be received |
| txPll | output | 1 | PLL assigned to transmit |
| rxPll | output | 1 | PLL assigned to receive |

## Verification
If the window counter drifts, the decision edges move away from the expected multiples of WIN_CYCLES. A reference model that tracks the window phase then sees cfgValid or the status bits change a cycle early or late, within one window of the fault. A wrong threshold or mode table shows up as a wrong refDiv, fbMult or useDru at the second decision after a rate change. A lost previous-mode register shows up either as cfgValid rising on the first decision after reset or after a change, or as cfgValid never rising. Rates are chosen well away from the thresholds, and the model ignores only the windows that straddle a rate change.

// File: rtl/tmds_pll_pkg.sv
`timescale 1ns/1ps
package tmds_pll_pkg;

  // Measured-rate class of one window.
  typedef enum logic [2:0] {
    BAND_NONE = 3'd0,
    BAND_DRU  = 3'd1,
    BAND_X20  = 3'd2,
    BAND_X10  = 3'd3,
    BAND_OVER = 3'd4
  } band_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic sample;  // close window, latch count and class
    logic load;    // confirm the class: load settings, raise valid
    logic drop;    // reject: clear valid, refresh status
  } dpCtl_t;

endpackage

// File: rtl/tmds_rate_dp.sv
`timescale 1ns/1ps
module tmds_rate_dp
  import tmds_pll_pkg::*;
#(
  parameter int unsigned REF_KHZ    = 100000,
  parameter int unsigned WIN_CYCLES = 200,
  parameter int unsigned CNT_W      = 12
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             tmdsClk,
  input  logic             txPllSel,
  input  dpCtl_t           ctl,
  output logic [CNT_W-1:0] measCount,
  output band_e            band,
  output logic             vcoOk,
  output logic             cfgValid,
  output logic [1:0]       refDiv,
  output logic [4:0]       fbMult,
  output logic             useDru,
  output logic             noClock,
  output logic             unsupported,
  output logic             txPll,
  output logic             rxPll
);

  localparam int unsigned PW = CNT_W + 5;
  localparam logic [CNT_W-1:0] THR_LO  = CNT_W'((64'd80000  * WIN_CYCLES) / REF_KHZ);
  localparam logic [CNT_W-1:0] THR_MID = CNT_W'((64'd165000 * WIN_CYCLES) / REF_KHZ);
  localparam logic [CNT_W-1:0] THR_HI  = CNT_W'((64'd330000 * WIN_CYCLES) / REF_KHZ);
  localparam logic [PW-1:0]    VCO_LO  = PW'((64'd1600000 * WIN_CYCLES) / REF_KHZ);
  localparam logic [PW-1:0]    VCO_HI  = PW'((64'd3300000 * WIN_CYCLES) / REF_KHZ);

  // TMDS domain: binary counter with a registered gray copy.
  logic [CNT_W-1:0] tBin, tBinNext, tGray;
  assign tBinNext = tBin + 1'b1;

  always_ff @(posedge tmdsClk or negedge rstN) begin
    if (!rstN) begin
      tBin  <= '0;
      tGray <= '0;
    end else begin
      tBin  <= tBinNext;
      tGray <= tBinNext ^ (tBinNext >> 1);
    end
  end

  // Reference domain: two-flop sync of the gray value, then decode.
  logic [CNT_W-1:0] sync1, sync2, syncBin, lastBin, delta;

  always_comb begin
    for (int i = 0; i < int'(CNT_W); i++) begin
      syncBin[i] = ^(sync2 >> i);
    end
  end

  assign delta = syncBin - lastBin;

  function automatic band_e classify(input logic [CNT_W-1:0] c);
    if (c == '0)          return BAND_NONE;
    else if (c < THR_LO)  return BAND_DRU;
    else if (c <= THR_MID) return BAND_X20;
    else if (c < THR_HI)  return BAND_X10;
    else                  return BAND_OVER;
  endfunction

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      sync1     <= '0;
      sync2     <= '0;
      lastBin   <= '0;
      measCount <= '0;
      band      <= BAND_NONE;
    end else begin
      sync1 <= tGray;
      sync2 <= sync1;
      if (ctl.sample) begin
        lastBin   <= syncBin;
        measCount <= delta;
        band      <= classify(delta);
      end
    end
  end

  // VCO legality in count units.
  logic [PW-1:0] vcoX20, vcoX10;
  assign vcoX20 = PW'(measCount) * PW'(20);
  assign vcoX10 = PW'(measCount) * PW'(10);

  always_comb begin
    case (band)
      BAND_DRU: vcoOk = 1'b1;
      BAND_X20: vcoOk = (vcoX20 >= VCO_LO) && (vcoX20 <= VCO_HI);
      BAND_X10: vcoOk = (vcoX10 >= VCO_LO) && (vcoX10 <= VCO_HI);
      default:  vcoOk = 1'b0;
    endcase
  end

  logic bandSupported;
  assign bandSupported = (band == BAND_DRU) || (band == BAND_X20) || (band == BAND_X10);

  // Decision registers.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      cfgValid    <= 1'b0;
      refDiv      <= '0;
      fbMult      <= '0;
      useDru      <= 1'b0;
      noClock     <= 1'b0;
      unsupported <= 1'b0;
    end else if (ctl.load) begin
      cfgValid    <= 1'b1;
      noClock     <= 1'b0;
      unsupported <= 1'b0;
      case (band)
        BAND_DRU: begin refDiv <= 2'd2; fbMult <= 5'd25; useDru <= 1'b1; end
        BAND_X20: begin refDiv <= 2'd1; fbMult <= 5'd20; useDru <= 1'b0; end
        default:  begin refDiv <= 2'd1; fbMult <= 5'd10; useDru <= 1'b0; end
      endcase
    end else if (ctl.drop) begin
      cfgValid    <= 1'b0;
      noClock     <= (band == BAND_NONE);
      unsupported <= (band == BAND_OVER) || (bandSupported && !vcoOk);
    end
  end

  // PLL split: receive always takes the other PLL.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      txPll <= 1'b0;
      rxPll <= 1'b1;
    end else begin
      txPll <= txPllSel;
      rxPll <= ~txPllSel;
    end
  end

endmodule

// File: rtl/tmds_pll_ctl.sv
`timescale 1ns/1ps
module tmds_pll_ctl
  import tmds_pll_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 200
) (
  input  logic   refClk,
  input  logic   rstN,
  input  band_e  band,
  input  logic   vcoOk,
  output dpCtl_t ctl
);

  localparam int unsigned WW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYCLES - 1);

  logic [WW-1:0] winCnt;
  logic          evalPend;
  band_e         prevBand;
  logic          supported;
  logic          confirm;

  assign supported = (band == BAND_DRU) || (band == BAND_X20) || (band == BAND_X10);
  assign confirm   = evalPend && supported && vcoOk && (band == prevBand);

  always_comb begin
    ctl.sample = (winCnt == WIN_LAST);
    ctl.load   = confirm;
    ctl.drop   = evalPend && !confirm;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winCnt   <= '0;
      evalPend <= 1'b0;
      prevBand <= BAND_NONE;
    end else begin
      winCnt   <= (winCnt == WIN_LAST) ? '0 : winCnt + 1'b1;
      evalPend <= (winCnt == WIN_LAST);
      if (evalPend) prevBand <= band;
    end
  end

endmodule

// File: rtl/tmds_pll_mode_sel.sv
`timescale 1ns/1ps
module tmds_pll_mode_sel
  import tmds_pll_pkg::*;
#(
  parameter int unsigned REF_KHZ    = 100000,
  parameter int unsigned WIN_CYCLES = 200
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       tmdsClk,
  input  logic       txPllSel,
  output logic       cfgValid,
  output logic [1:0] refDiv,
  output logic [4:0] fbMult,
  output logic       useDru,
  output logic       noClock,
  output logic       unsupported,
  output logic       txPll,
  output logic       rxPll
);

  localparam longint unsigned HI_CNT = (64'd330000 * WIN_CYCLES) / REF_KHZ;
  localparam int unsigned CNT_W = $clog2(HI_CNT * 4);

  dpCtl_t           ctl;
  logic [CNT_W-1:0] measCount;
  band_e            band;
  logic             vcoOk;

  tmds_pll_ctl #(.WIN_CYCLES(WIN_CYCLES)) u_ctl (
    .refClk(refClk), .rstN(rstN), .band(band), .vcoOk(vcoOk), .ctl(ctl)
  );

  tmds_rate_dp #(.REF_KHZ(REF_KHZ), .WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_dp (
    .refClk(refClk), .rstN(rstN), .tmdsClk(tmdsClk), .txPllSel(txPllSel),
    .ctl(ctl), .measCount(measCount), .band(band), .vcoOk(vcoOk),
    .cfgValid(cfgValid), .refDiv(refDiv), .fbMult(fbMult), .useDru(useDru),
    .noClock(noClock), .unsupported(unsupported), .txPll(txPll), .rxPll(rxPll)
  );

endmodule

// File: rtl/tmds_pll_mode_sel_chk.sv
`timescale 1ns/1ps
module tmds_pll_mode_sel_chk
  import tmds_pll_pkg::*;
#(
  parameter int unsigned REF_KHZ    = 100000,
  parameter int unsigned WIN_CYCLES = 200,
  parameter int unsigned CNT_W      = 12
) (
  input logic             refClk,
  input logic             rstN,
  input logic             cfgValid,
  input logic [1:0]       refDiv,
  input logic [4:0]       fbMult,
  input logic             useDru,
  input logic             noClock,
  input logic             unsupported,
  input logic             txPll,
  input logic             rxPll,
  input dpCtl_t           ctl,
  input logic [CNT_W-1:0] measCount,
  input band_e            band
);

  localparam int unsigned PW = CNT_W + 5;
  localparam logic [CNT_W-1:0] THR_MID = CNT_W'((64'd165000 * WIN_CYCLES) / REF_KHZ);
  localparam logic [PW-1:0] VCO_LO = PW'((64'd1600000 * WIN_CYCLES) / REF_KHZ);
  localparam logic [PW-1:0] VCO_HI = PW'((64'd3300000 * WIN_CYCLES) / REF_KHZ);

  logic [1:0]    decCnt;
  logic [PW-1:0] vcoProd;
  assign vcoProd = PW'(measCount) * PW'(fbMult);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) decCnt <= '0;
    else if ((ctl.load || ctl.drop) && decCnt != 2'd3) decCnt <= decCnt + 1'b1;
  end

  p_pll_split_r9: assert property (@(posedge refClk) disable iff (!rstN)
    rxPll != txPll);

  p_valid_excl_r7: assert property (@(posedge refClk) disable iff (!rstN)
    cfgValid |-> (!noClock && !unsupported));

  p_dru_fields_r3: assert property (@(posedge refClk) disable iff (!rstN)
    (cfgValid && useDru) |-> (refDiv == 2'd2 && fbMult == 5'd25));

  p_cdr_fields_r4: assert property (@(posedge refClk) disable iff (!rstN)
    (cfgValid && !useDru) |-> (refDiv == 2'd1 && (fbMult == 5'd20 || fbMult == 5'd10)));

  p_hold_r2: assert property (@(posedge refClk) disable iff (!rstN)
    !(ctl.load || ctl.drop) |=> ($stable(cfgValid) && $stable(fbMult) && $stable(refDiv)
                                 && $stable(noClock) && $stable(unsupported)));

  p_confirm_r8: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(cfgValid) |-> (decCnt >= 2'd2));

  p_edge_r4: assert property (@(posedge refClk) disable iff (!rstN)
    (ctl.load && measCount == THR_MID) |=> (fbMult == 5'd20));

  p_vco_r10: assert property (@(posedge refClk) disable iff (!rstN)
    (ctl.load && band != BAND_DRU) |=> (vcoProd >= VCO_LO && vcoProd <= VCO_HI));

  p_over_r6: assert property (@(posedge refClk) disable iff (!rstN)
    (ctl.drop && band == BAND_OVER) |=> (unsupported && !cfgValid));

endmodule

bind tmds_pll_mode_sel tmds_pll_mode_sel_chk #(
  .REF_KHZ(REF_KHZ), .WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)
) u_chk (
  .refClk(refClk), .rstN(rstN), .cfgValid(cfgValid), .refDiv(refDiv),
  .fbMult(fbMult), .useDru(useDru), .noClock(noClock), .unsupported(unsupported),
  .txPll(txPll), .rxPll(rxPll), .ctl(ctl), .measCount(measCount), .band(band)
);

// File: tb/tmds_pll_mode_sel_bench.sv
`timescale 1ns/1ps
module tmds_pll_mode_sel_bench;

  localparam int WIN = 200;

  logic refClk = 1'b0;
  logic tmdsClk = 1'b0;
  logic rstN = 1'b0;
  logic txPllSel = 1'b0;
  logic cfgValid, useDru, noClock, unsupported, txPll, rxPll;
  logic [1:0] refDiv;
  logic [4:0] fbMult;

  tmds_pll_mode_sel #(.REF_KHZ(100000), .WIN_CYCLES(WIN)) u_tmds_pll_mode_sel (
    .refClk(refClk), .rstN(rstN), .tmdsClk(tmdsClk), .txPllSel(txPllSel),
    .cfgValid(cfgValid), .refDiv(refDiv), .fbMult(fbMult), .useDru(useDru),
    .noClock(noClock), .unsupported(unsupported), .txPll(txPll), .rxPll(rxPll)
  );

  always #5 refClk = ~refClk;

  real freqMhz = 120.0;
  always begin
    if (freqMhz > 0.0) begin
      #(500.0 / freqMhz) tmdsClk = ~tmdsClk;
    end else begin
      #1;
    end
  end

  int totalCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: window phase, previous mode, confirmed settings.
  int n = 0;
  int decCount = 0;
  int skip = 0;
  int mPrev = 0;
  int mValid = 0, mDiv = 0, mMult = 0, mDru = 0, mNo = 0, mUns = 0;
  int mTx = 0;

  function automatic int bandOf(input real f);
    if (f <= 0.0) return 0;
    if (f < 80.0) return 1;
    if (f <= 165.0) return 2;
    if (f < 330.0) return 3;
    return 4;
  endfunction

  always @(posedge refClk) begin
    if (!rstN) begin
      n = 0; mPrev = 0; mValid = 0; mDiv = 0; mMult = 0; mDru = 0;
      mNo = 0; mUns = 0; mTx = 0;
    end else begin
      n++;
      mTx = int'(txPllSel);
      if (n > WIN && ((n - 1) % WIN) == 0) begin
        int b;
        b = bandOf(freqMhz);
        if (b == mPrev && b >= 1 && b <= 3) begin
          mValid = 1; mNo = 0; mUns = 0;
          mDiv = (b == 1) ? 2 : 1;
          mMult = (b == 1) ? 25 : ((b == 2) ? 20 : 10);
          mDru = (b == 1) ? 1 : 0;
        end else begin
          mValid = 0;
          mNo = (b == 0) ? 1 : 0;
          mUns = (b == 4) ? 1 : 0;
        end
        mPrev = b;
        if (skip > 0) skip--;
        decCount++;
      end
    end
  end

  // Every-clock comparison against the model.
  always @(negedge refClk) begin
    if (rstN && skip == 0 && !finished) begin
      chk(cfgValid == mValid, "R2/R8 cfgValid", cfgValid, mValid);
      chk(refDiv == mDiv, "R3/R4/R5/R11 refDiv", refDiv, mDiv);
      chk(fbMult == mMult, "R3/R4/R5/R11 fbMult", fbMult, mMult);
      chk(useDru == mDru, "R3 useDru", useDru, mDru);
      chk(noClock == mNo, "R7 noClock", noClock, mNo);
      chk(unsupported == mUns, "R6 unsupported", unsupported, mUns);
      chk(txPll == mTx, "R9 txPll", txPll, mTx);
      chk(rxPll == !mTx, "R9 rxPll", rxPll, int'(!mTx));
    end
  end

  task automatic waitDec(input int k);
    int tgt;
    tgt = decCount + k;
    while (decCount < tgt) @(negedge refClk);
  endtask

  task automatic setFreq(input real f);
    @(negedge refClk);
    while ((n % WIN) != WIN / 2) @(negedge refClk);
    freqMhz = f;
    skip = 3;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  endtask

  initial begin
    #500000;
    totalCnt++;
    failCnt++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", decCount, 18);
    finish();
  end

  initial begin
    repeat (4) @(negedge refClk);
    // R1 reset state
    chk(cfgValid == 0, "R1 cfgValid", cfgValid, 0);
    chk(noClock == 0, "R1 noClock", noClock, 0);
    chk(unsupported == 0, "R1 unsupported", unsupported, 0);
    chk(refDiv == 0 && fbMult == 0 && useDru == 0, "R1 settings", fbMult, 0);
    chk(txPll == 0 && rxPll == 1, "R1 pll split", rxPll, 1);
    rstN = 1'b1;

    // R8: first decision never valid, second confirms x20 at 120 MHz
    waitDec(1);
    chk(cfgValid == 0, "R8 first decision", cfgValid, 0);
    waitDec(1);
    chk(cfgValid == 1, "R8 second decision", cfgValid, 1);
    chk(fbMult == 20 && refDiv == 1 && useDru == 0, "R4 x20 mode", fbMult, 20);
    chk(fbMult * 120 >= 1600 && fbMult * 120 <= 3300, "R10 vco x20", fbMult * 120, 2400);

    setFreq(50.0);
    waitDec(3);
    chk(cfgValid == 1 && useDru == 1, "R3 oversampling", useDru, 1);
    chk(refDiv == 2 && fbMult == 25, "R3 div/mult", fbMult, 25);

    setFreq(250.0);
    waitDec(3);
    chk(cfgValid == 1 && fbMult == 10 && refDiv == 1, "R5 x10 mode", fbMult, 10);
    chk(fbMult * 250 >= 1600 && fbMult * 250 <= 3300, "R10 vco x10", fbMult * 250, 2500);

    @(negedge refClk);
    txPllSel = 1'b1;
    @(negedge refClk);
    chk(txPll == 1 && rxPll == 0, "R9 swap", txPll, 1);

    setFreq(400.0);
    waitDec(3);
    chk(unsupported == 1 && cfgValid == 0, "R6 over range", unsupported, 1);
    chk(fbMult == 10 && refDiv == 1 && useDru == 0, "R11 settings held", fbMult, 10);

    setFreq(0.0);
    waitDec(3);
    chk(noClock == 1 && cfgValid == 0 && unsupported == 0, "R7 no clock", noClock, 1);

    setFreq(150.0);
    waitDec(3);
    chk(cfgValid == 1 && fbMult == 20 && noClock == 0, "R4 recover", fbMult, 20);

    repeat (WIN) @(negedge refClk);
    finish();
  end

endmodule